// File: doc/BRIEF.md
# NAND Flash Controller Control and Status Registers

This block is the register front end of a NAND flash controller. It sits on a simple 32-bit word-addressed register bus and holds the settings the flash sequencer reads: an interface configuration word, a timing word and a chip-enable mode bit. The configuration and timing words are guarded by a key. Writing the key opens them for exactly one write, and the guard closes again by itself after that write.

On the event side, the datapath reports the flash device and controller ready levels, a per-sector decode completion with error, failure and correction-count qualifiers, and write-protect faults. These set sticky interrupt flags. The flags are cleared when software reads them, and they are gated by a mask onto one level-high interrupt line. A live status word reports the current ready levels and the outcome of the most recent decode. A reset command clears the event state and closes the key guard.

Top module: `nfc_csr`

Register word addresses (`addr_i`): 0 command, 1 interface configuration, 2 timing, 3 interrupt mask, 4 interrupt status, 5 key/lock, 6 live status, 7 chip-enable mode.

## Requirements
- R1: After reset the interrupt mask, interrupt status, configuration, timing and chip-enable registers are zero, the guard is closed (key/lock reads 0), and `irq_o` is low.
- R2: A write to address 5 whose low 16 bits are 0xA25E opens the guard, and the upper bits are ignored. While the guard is open, a read of address 5 returns 1 in bit 0. While it is closed, the read returns 0.
- R3: While the guard is open, one write to address 1 (configuration, bits 3:0: write-protect enable, large block, long address, 16-bit bus) or to address 2 (timing, bits 26:0) takes effect and closes the guard.
- R4: A write to address 1 or 2 while the guard is closed changes nothing and leaves the guard closed.
- R5: A write to address 5 with any other low 16-bit value closes the guard.
- R6: Interrupt status bits are set as follows. Bit 5 is set on a rising edge of `nand_rdy_i`. Bit 4 is set on a rising edge of `ctl_rdy_i`. Bit 1 is set by `ecc_done_i`. Bit 2 is set by `ecc_done_i` with `dec_err_i`. Bit 3 is set by `ecc_done_i` with `dec_fail_i`. Bit 0 is set by `wp_fault_i`. A set bit stays set until it is cleared.
- R7: A read of address 4 returns the status bits latched before that cycle and clears them. An event arriving in the same cycle as the read stays latched for the next read.
- R8: `irq_o` is high exactly when some status bit and the same mask bit (address 3, same layout) are both 1.
- R9: Live status (address 6) holds `nand_rdy_i` in bit 0 and `ctl_rdy_i` in bit 1. Bit 2 is the ECC-ready flag. Bit 3 is the decode error, bits 5:4 are the correction count minus one, and bit 6 is the decode failure. Bits 6:2 are captured at each `ecc_done_i`.
- R10: Writing the full word 0xFF to address 0 clears the interrupt status and live bits 6:2 and closes the guard. Configuration, timing and mask are kept. Any other command value has no effect.
- R11: Bit 0 of address 7 drives `ce_normal_o`, which selects controller-driven chip enable.
- R12: Read data appears on `rdata_o` in the cycle after the read request and holds until the next read. Reads of addresses other than 4 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| nand_rdy_i | input | 1 | Flash device ready level |
| ctl_rdy_i | input | 1 | Controller ready level |
| ecc_done_i | input | 1 | Decode of one sector finished (pulse) |
| dec_err_i | input | 1 | Correctable errors found, qualified by ecc_done_i |
| dec_fail_i | input | 1 | Uncorrectable sector, qualified by ecc_done_i |
| err_cnt_i | input | 2 | Corrections minus one, qualified by ecc_done_i |
| wp_fault_i | input | 1 | Write-protect fault pulse |
| cfg_o | output | 4 | Interface configuration |
| timing_o | output | 27 | Timing word |
| ce_normal_o | output | 1 | Controller drives chip enable |
| irq_o | output | 1 | Interrupt, level high |

## Verification
The assertions take for granted that the bus carries at most one access per cycle and that `dec_err_i`, `dec_fail_i` and `err_cnt_i` matter only while `ecc_done_i` is high. The stimulus drives each access as a single-cycle request. It raises the decode qualifiers only together with `ecc_done_i`, and it never forms an event combination that the datapath cannot produce, such as a decode error without decode completion. Ready levels are dropped after each sweep step, so that the next rising edge is a fresh one.

// File: rtl/nfc_csr_pkg.sv
package nfc_csr_pkg;
  typedef enum logic [2:0] {
    A_CMD    = 3'd0,
    A_IFCFG  = 3'd1,
    A_TIMING = 3'd2,
    A_IMASK  = 3'd3,
    A_ISTAT  = 3'd4,
    A_KEY    = 3'd5,
    A_LIVE   = 3'd6,
    A_CE     = 3'd7
  } reg_addr_e;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [31:0] CMD_RESET  = 32'h0000_00FF;
  localparam int unsigned NEV  = 6;
  localparam int unsigned LV_W = 7;

  // interrupt bit positions
  localparam int unsigned IB_WP    = 0;
  localparam int unsigned IB_ECC   = 1;
  localparam int unsigned IB_DERR  = 2;
  localparam int unsigned IB_DFAIL = 3;
  localparam int unsigned IB_CTL   = 4;
  localparam int unsigned IB_NAND  = 5;
endpackage

// File: rtl/nfc_csr_lock.sv
module nfc_csr_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_wr_i,
  input  logic key_ok_i,
  input  logic prot_wr_i,
  input  logic cmd_rst_i,
  output logic unlocked_o,
  output logic commit_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        open_q <= 1'b0;
    else if (cmd_rst_i) open_q <= 1'b0;
    else if (key_wr_i)  open_q <= key_ok_i;
    else if (prot_wr_i) open_q <= 1'b0;  // one write per unlock
  end

  assign unlocked_o = open_q;
  assign commit_o   = prot_wr_i & open_q;
endmodule

// File: rtl/nfc_csr_evt.sv
module nfc_csr_evt
  import nfc_csr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nand_rdy_i,
  input  logic            ctl_rdy_i,
  input  logic            ecc_done_i,
  input  logic            dec_err_i,
  input  logic            dec_fail_i,
  input  logic [1:0]      err_cnt_i,
  input  logic            wp_fault_i,
  input  logic            cmd_rst_i,
  output logic [NEV-1:0]  set_o,
  output logic [LV_W-1:0] live_o
);
  logic nand_prev_q, ctl_prev_q;
  logic ecc_v_q, err_v_q, fail_v_q;
  logic [1:0] cnt_q;

  // prev reset high: a level already high out of reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nand_prev_q <= 1'b1;
      ctl_prev_q  <= 1'b1;
    end else begin
      nand_prev_q <= nand_rdy_i;
      ctl_prev_q  <= ctl_rdy_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_v_q  <= 1'b0;
      err_v_q  <= 1'b0;
      fail_v_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cmd_rst_i) begin
      ecc_v_q  <= 1'b0;
      err_v_q  <= 1'b0;
      fail_v_q <= 1'b0;
      cnt_q    <= '0;
    end else if (ecc_done_i) begin
      ecc_v_q  <= 1'b1;
      err_v_q  <= dec_err_i;
      fail_v_q <= dec_fail_i;
      cnt_q    <= err_cnt_i;
    end
  end

  always_comb begin
    set_o           = '0;
    set_o[IB_WP]    = wp_fault_i;
    set_o[IB_ECC]   = ecc_done_i;
    set_o[IB_DERR]  = ecc_done_i & dec_err_i;
    set_o[IB_DFAIL] = ecc_done_i & dec_fail_i;
    set_o[IB_CTL]   = ctl_rdy_i & ~ctl_prev_q;
    set_o[IB_NAND]  = nand_rdy_i & ~nand_prev_q;
  end

  assign live_o = {fail_v_q, cnt_q, err_v_q, ecc_v_q, ctl_rdy_i, nand_rdy_i};
endmodule

// File: rtl/nfc_csr_irq.sv
module nfc_csr_irq #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         stat_rd_i,
  input  logic         clr_all_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        st_q <= 1'b0;
      else if (clr_all_i) st_q <= 1'b0;
      else                st_q <= (st_q & ~stat_rd_i) | set_i[b];  // same-cycle event survives
    end
    assign stat_o[b] = st_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(stat_o & mask_q);
endmodule

// File: rtl/nfc_csr.sv
module nfc_csr
  import nfc_csr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CFG_W = 4,
  parameter int unsigned TIM_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             nand_rdy_i,
  input  logic             ctl_rdy_i,
  input  logic             ecc_done_i,
  input  logic             dec_err_i,
  input  logic             dec_fail_i,
  input  logic [1:0]       err_cnt_i,
  input  logic             wp_fault_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [TIM_W-1:0] timing_o,
  output logic             ce_normal_o,
  output logic             irq_o
);
  reg_addr_e addr;
  logic wr, rd, cmd_rst, key_wr, key_ok, prot_wr, commit, unlocked;
  logic [NEV-1:0]  ev_set, stat, mask;
  logic [LV_W-1:0] live;
  logic [CFG_W-1:0] cfg_q;
  logic [TIM_W-1:0] tim_q;
  logic ce_q;
  logic [DW-1:0] rmux, rdata_q;

  assign addr    = reg_addr_e'(addr_i);
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign cmd_rst = wr && addr == A_CMD && wdata_i == DW'(CMD_RESET);
  assign key_wr  = wr && addr == A_KEY;
  assign key_ok  = wdata_i[15:0] == UNLOCK_KEY;
  assign prot_wr = wr && (addr == A_IFCFG || addr == A_TIMING);

  nfc_csr_lock u_lock (
    .clk_i, .rst_ni,
    .key_wr_i  (key_wr),
    .key_ok_i  (key_ok),
    .prot_wr_i (prot_wr),
    .cmd_rst_i (cmd_rst),
    .unlocked_o(unlocked),
    .commit_o  (commit)
  );

  nfc_csr_evt u_evt (
    .clk_i, .rst_ni,
    .nand_rdy_i, .ctl_rdy_i, .ecc_done_i, .dec_err_i, .dec_fail_i,
    .err_cnt_i, .wp_fault_i,
    .cmd_rst_i(cmd_rst),
    .set_o    (ev_set),
    .live_o   (live)
  );

  nfc_csr_irq #(.N(NEV)) u_irq (
    .clk_i, .rst_ni,
    .set_i       (ev_set),
    .stat_rd_i   (rd && addr == A_ISTAT),
    .clr_all_i   (cmd_rst),
    .mask_wr_i   (wr && addr == A_IMASK),
    .mask_wdata_i(wdata_i[NEV-1:0]),
    .stat_o      (stat),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      tim_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      if (commit && addr == A_IFCFG)  cfg_q <= wdata_i[CFG_W-1:0];
      if (commit && addr == A_TIMING) tim_q <= wdata_i[TIM_W-1:0];
      if (wr && addr == A_CE)         ce_q  <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr)
      A_IFCFG:  rmux = DW'(cfg_q);
      A_TIMING: rmux = DW'(tim_q);
      A_IMASK:  rmux = DW'(mask);
      A_ISTAT:  rmux = DW'(stat);
      A_KEY:    rmux = DW'(unlocked);
      A_LIVE:   rmux = DW'(live);
      A_CE:     rmux = DW'(ce_q);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rmux;
  end

  assign rdata_o     = rdata_q;
  assign cfg_o       = cfg_q;
  assign timing_o    = tim_q;
  assign ce_normal_o = ce_q;
endmodule

// File: rtl/nfc_csr_chk.sv
module nfc_csr_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CFG_W = 4,
  parameter int unsigned TIM_W = 27,
  parameter int unsigned N     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             unlocked_i,
  input logic [N-1:0]     stat_i,
  input logic [N-1:0]     mask_i,
  input logic [N-1:0]     set_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic [TIM_W-1:0] timing_i,
  input logic             irq_i
);
  logic prot_wr;
  assign prot_wr = req_i && we_i && (addr_i == 3'd1 || addr_i == 3'd2);

  // R2
  key_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 3'd5 && wdata_i[15:0] == 16'hA25E) |=> unlocked_i);

  // R3
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_wr && unlocked_i) |=> !unlocked_i);

  // R4
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_wr && !unlocked_i) |=> (!unlocked_i && $stable(cfg_i) && $stable(timing_i)));

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 3'd4 && set_i == '0) |=> stat_i == '0);

  // R8
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0 || mask_i == '0) |-> !irq_i);

  // R10
  cmd_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 3'd0 && wdata_i == DW'(32'hFF)) |=> (stat_i == '0 && !unlocked_i));
endmodule

bind nfc_csr nfc_csr_chk #(.DW(DW), .CFG_W(CFG_W), .TIM_W(TIM_W), .N(nfc_csr_pkg::NEV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .unlocked_i(unlocked),
  .stat_i    (stat),
  .mask_i    (mask),
  .set_i     (ev_set),
  .cfg_i     (cfg_o),
  .timing_i  (timing_o),
  .irq_i     (irq_o)
);

// File: tb/nfc_csr_tb.sv
module nfc_csr_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic nand_rdy_i = 1'b0, ctl_rdy_i = 1'b0, ecc_done_i = 1'b0;
  logic dec_err_i = 1'b0, dec_fail_i = 1'b0, wp_fault_i = 1'b0;
  logic [1:0] err_cnt_i = '0;
  logic [3:0] cfg_o;
  logic [26:0] timing_o;
  logic ce_normal_o, irq_o;

  int nchk = 0, nfail = 0;

  always #4 clk_i = ~clk_i;

  nfc_csr u_dut (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic events(input logic [5:0] s);
    @(negedge clk_i);
    nand_rdy_i = s[5]; ctl_rdy_i = s[4]; wp_fault_i = s[0];
    ecc_done_i = s[1] | s[2] | s[3]; dec_err_i = s[2]; dec_fail_i = s[3];
    @(negedge clk_i);
    nand_rdy_i = 1'b0; ctl_rdy_i = 1'b0; wp_fault_i = 1'b0;
    ecc_done_i = 1'b0; dec_err_i = 1'b0; dec_fail_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [5:0] e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1
    chk("R1 cfg", 32'(cfg_o), 0);
    chk("R1 timing", 32'(timing_o), 0);
    chk("R1 ce", 32'(ce_normal_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(3'd3, d); chk("R1 mask", d, 0);
    rd(3'd5, d); chk("R1 lock", d, 0);
    rd(3'd4, d); chk("R1 status", d, 0);

    // R4 locked write ignored
    wr(3'd1, 32'hF);
    chk("R4 cfg", 32'(cfg_o), 0);
    rd(3'd5, d); chk("R4 lock", d, 0);

    // R2, R3
    wr(3'd5, 32'hFFFF_A25E);
    rd(3'd5, d); chk("R2 unlocked", d, 1);
    wr(3'd1, 32'hB);
    chk("R3 cfg", 32'(cfg_o), 32'hB);
    rd(3'd5, d); chk("R3 relocked", d, 0);
    wr(3'd1, 32'h4);
    chk("R4 second write", 32'(cfg_o), 32'hB);
    rd(3'd1, d); chk("R12 cfg readback", d, 32'hB);
    for (int i = 0; i < 32; i++) begin
      logic [26:0] v;
      v = 27'((i + 1) * 32'h0123_4577);
      wr(3'd5, 32'h0000_A25E);
      wr(3'd2, 32'(v));
      chk("R3 timing", 32'(timing_o), 32'(v));
      wr(3'd2, 32'(~v));
      chk("R4 timing locked", 32'(timing_o), 32'(v));
      rd(3'd2, d); chk("R12 timing readback", d, 32'(v));
    end

    // R5
    wr(3'd5, 32'h0000_A25E);
    wr(3'd5, 32'h0000_1234);
    rd(3'd5, d); chk("R5 wrong key", d, 0);
    wr(3'd1, 32'h1);
    chk("R5 cfg kept", 32'(cfg_o), 32'hB);

    // R11
    wr(3'd7, 32'h1);
    chk("R11 ce on", 32'(ce_normal_o), 1);
    rd(3'd7, d); chk("R11 ce read", d, 1);
    wr(3'd7, 32'h2);
    chk("R11 ce off", 32'(ce_normal_o), 0);

    // R6, R7, R8 sweep
    for (int s = 0; s < 64; s++) begin
      e = 6'(s) | {4'b0, (s[2] | s[3]), 1'b0};
      events(6'(s));
      for (int m = 0; m < 64; m++) begin
        wr(3'd3, 32'(m));
        chk("R8 irq", 32'(irq_o), 32'(|(e & 6'(m))));
      end
      rd(3'd4, d); chk("R6 status", d, 32'(e));
      chk("R12 rdata hold", rdata_o, 32'(e));
      rd(3'd4, d); chk("R7 cleared", d, 0);
    end
    wr(3'd3, 32'h0);

    // R7 same-cycle event survives the read
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 3'd4; wp_fault_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; wp_fault_i = 1'b0;
    chk("R7 read during event", rdata_o, 0);
    rd(3'd4, d); chk("R7 event kept", d, 1);

    // R9 live status
    for (int c = 0; c < 4; c++)
      for (int er = 0; er < 2; er++)
        for (int f = 0; f < 2; f++) begin
          @(negedge clk_i);
          nand_rdy_i = 1'b1; ctl_rdy_i = c[0];
          ecc_done_i = 1'b1; dec_err_i = er[0]; dec_fail_i = f[0]; err_cnt_i = 2'(c);
          @(negedge clk_i);
          ecc_done_i = 1'b0; dec_err_i = 1'b0; dec_fail_i = 1'b0; err_cnt_i = '0;
          rd(3'd6, d);
          chk("R9 live", d, 32'({f[0], 2'(c), er[0], 1'b1, c[0], 1'b1}));
        end
    @(negedge clk_i);
    nand_rdy_i = 1'b0; ctl_rdy_i = 1'b0;
    rd(3'd4, d);

    // R10
    events(6'b000001);
    wr(3'd3, 32'h1);
    wr(3'd5, 32'h0000_A25E);
    wr(3'd0, 32'h0000_0012);
    chk("R10 other cmd irq", 32'(irq_o), 1);
    rd(3'd5, d); chk("R10 other cmd lock", d, 1);
    wr(3'd0, 32'h0000_00FF);
    chk("R10 reset irq", 32'(irq_o), 0);
    rd(3'd5, d); chk("R10 reset lock", d, 0);
    rd(3'd6, d); chk("R10 live cleared", d, 0);
    rd(3'd3, d); chk("R10 mask kept", d, 1);
    chk("R10 cfg kept", 32'(cfg_o), 32'hB);
    rd(3'd4, d); chk("R10 status cleared", d, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule